// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block holds a 16-bit up-counter that advances once per prescaled tick. The tick comes from a divider whose ratio is picked by a two-bit field in a control byte. Other logic, such as capture and compare units, reads the count directly from a dedicated output. When the count rolls over from all ones to zero, the block sets an overflow flag. That flag, gated by an enable bit, drives an interrupt request line.

Software reaches the block through a byte-wide register port with a three-bit address. There are five registers:

| Offset | Register |
|--------|----------|
| 0 | Counter high byte |
| 1 | Counter low byte |
| 2 | Control byte |
| 3 | Status byte |
| 4 | Rate byte (stored only) |

Either counter byte can be written on its own, and any write to the counter restarts the divider phase. Reading the high byte captures the low byte, so the two halves of one count can be read in two separate accesses. The divider ratio can only be changed during a short window after reset. After that window closes, the ratio stays as it was.

Top module: `prescaled_timer`

## Requirements
- R1: On every prescaled tick with no counter write in the same cycle, the count increases by exactly one, modulo 2^16. With the default divide-by-one it advances on every clock edge.
- R2: Control byte bits [1:0] select the divider: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16 clock cycles per tick.
- R3: A control write takes bits [1:0] only while fewer than LOCK_CYCLES (default 64) clock edges have passed since reset. A later control write leaves bits [1:0] unchanged and still updates bits [7:2].
- R4: Status bit 7 (the overflow flag) becomes 1 on the clock edge at which the count steps from 0xFFFF to 0x0000.
- R5: A write to the status byte clears the overflow flag when written bit 7 is 1 and leaves it unchanged when written bit 7 is 0.
- R6: A write to offset 0 replaces the high byte and keeps the current low byte. A write to offset 1 replaces the low byte and keeps the current high byte. A counter write takes priority over a tick in the same cycle. After the write, the next tick comes a full divider period later.
- R7: A read of offset 0 captures the low byte present at that edge. The next read of offset 1 returns the captured byte. A read of offset 1 with no capture pending returns the live low byte.
- R8: The interrupt request is high exactly when the overflow flag is 1 and control bit 7 (the overflow interrupt enable) is 1.
- R9: After reset the count, the control byte, the status byte and the rate byte (offset 4, fully read/write) are all zero.
- R10: Read data appears on the data output one clock edge after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| count_o | output | 16 | Live counter value |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The divider phase is hidden state, so the bench always restarts it with a low-byte write before measuring. After that write, a wrong phase or a wrong divider decode shifts the first increment of `count_o` off the expected edge within one divider period, which is at most 16 cycles.

A select field that stays writable after the window closes shows up on the very next control read. A lost or stuck overflow flag shows up on `ovf_irq_o` in the cycle after the wrap. A stale or missing low-byte capture shows up as a wrong low byte on the first low read after a high read that was separated from it by several ticks.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
   localparam logic [2:0] OFS_CNT_HI = 3'd0;
   localparam logic [2:0] OFS_CNT_LO = 3'd1;
   localparam logic [2:0] OFS_CTRL   = 3'd2;
   localparam logic [2:0] OFS_STAT   = 3'd3;
   localparam logic [2:0] OFS_RATE   = 3'd4;

   localparam int FLAG_BIT = 7;
   localparam int IEN_BIT  = 7;

   // clock cycles per tick for each select code
   function automatic logic [4:0] div_of(input logic [1:0] sel);
      logic [4:0] d;
      case (sel)
         2'b00:   d = 5'd1;
         2'b01:   d = 5'd4;
         2'b10:   d = 5'd8;
         default: d = 5'd16;
      endcase
      return d;
   endfunction
endpackage

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
   parameter int PH_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       restart,
   output logic       tick
);
   import ptimer_pkg::*;

   if (PH_W < 5) begin : g_bad_width
      $error("PH_W must hold the largest divider");
   end

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] limit;

   assign limit = PH_W'(div_of(sel)) - PH_W'(1);
   // >= so that lowering the ratio mid-period does not stall the divider
   assign tick  = (phase_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)            phase_q <= '0;
      else if (restart)      phase_q <= '0;
      else if (tick)         phase_q <= '0;
      else                   phase_q <= phase_q + PH_W'(1);
   end

   // R2
   phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> (phase_q == $past(phase_q) + PH_W'(1)));

   // R6
   phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase_q == '0));
endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            wr_hi,
   input  logic            wr_lo,
   input  logic [DW-1:0]   wdata,
   output logic [2*DW-1:0] count,
   output logic            wrap
);
   localparam int CW = 2 * DW;

   logic [CW-1:0] cnt_q;

   assign count = cnt_q;
   assign wrap  = tick && !wr_hi && !wr_lo && (cnt_q == {CW{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (wr_hi) cnt_q <= {wdata, cnt_q[DW-1:0]};
      else if (wr_lo) cnt_q <= {cnt_q[CW-1:DW], wdata};
      else if (tick)  cnt_q <= cnt_q + CW'(1);
   end

   // R1
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_hi && !wr_lo) |=> (cnt_q == $past(cnt_q) + CW'(1)));

   // R6
   keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (cnt_q[DW-1:0] == $past(cnt_q[DW-1:0])));

   // R6
   keep_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (cnt_q[CW-1:DW] == $past(cnt_q[CW-1:DW])));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
   parameter int DATA_W      = 8,
   parameter int LOCK_CYCLES = 64,
   parameter bit LATCH_LOW   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [2*DATA_W-1:0] count_o,
   output logic                ovf_irq_o
);
   import ptimer_pkg::*;

   localparam int CW    = 2 * DATA_W;
   localparam int AGE_W = $clog2(LOCK_CYCLES + 1);

   if (DATA_W != 8) begin : g_bad_data
      $error("DATA_W must be 8");
   end
   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("LOCK_CYCLES must be positive");
   end

   logic [DATA_W-1:0] ctrl_q, rate_q, lo_rd, ctrl_next;
   logic              flag_q;
   logic [AGE_W-1:0]  age_q;
   logic              win_open;
   logic              wr_hi, wr_lo, wr_ctrl, wr_stat, wr_rate, rd_hi, rd_lo;
   logic              tick, wrap;

   assign wr_hi   = bus_wr && (bus_addr == OFS_CNT_HI);
   assign wr_lo   = bus_wr && (bus_addr == OFS_CNT_LO);
   assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
   assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
   assign wr_rate = bus_wr && (bus_addr == OFS_RATE);
   assign rd_hi   = bus_rd && (bus_addr == OFS_CNT_HI);
   assign rd_lo   = bus_rd && (bus_addr == OFS_CNT_LO);

   // edges since reset, saturating at the window length
   always_ff @(posedge clk) begin
      if (!rst_n)         age_q <= '0;
      else if (win_open)  age_q <= age_q + AGE_W'(1);
   end
   assign win_open = (age_q < AGE_W'(LOCK_CYCLES));

   ptimer_prescale #(.PH_W(5)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (ctrl_q[1:0]),
      .restart (wr_hi || wr_lo),
      .tick    (tick)
   );

   ptimer_count #(.DW(DATA_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wr_hi (wr_hi),
      .wr_lo (wr_lo),
      .wdata (bus_wdata),
      .count (count_o),
      .wrap  (wrap)
   );

   always_comb begin
      ctrl_next = bus_wdata;
      if (!win_open) ctrl_next[1:0] = ctrl_q[1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         rate_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_next;
         if (wr_rate) rate_q <= bus_wdata;
      end
   end

   // set beats clear when both land on one edge
   always_ff @(posedge clk) begin
      if (!rst_n)                           flag_q <= 1'b0;
      else if (wrap)                        flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[FLAG_BIT]) flag_q <= 1'b0;
   end

   assign ovf_irq_o = flag_q && ctrl_q[IEN_BIT];

   if (LATCH_LOW) begin : g_latch
      logic [DATA_W-1:0] hold_q;
      logic              hold_vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
         end else if (rd_hi) begin
            hold_q     <= count_o[DATA_W-1:0];
            hold_vld_q <= 1'b1;
         end else if (rd_lo) begin
            hold_vld_q <= 1'b0;
         end
      end
      assign lo_rd = hold_vld_q ? hold_q : count_o[DATA_W-1:0];

      // R7
      hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_hi |=> (hold_vld_q && hold_q == $past(count_o[DATA_W-1:0])));
   end else begin : g_direct
      assign lo_rd = count_o[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) begin
         case (bus_addr)
            OFS_CNT_HI: bus_rdata <= count_o[CW-1:DATA_W];
            OFS_CNT_LO: bus_rdata <= lo_rd;
            OFS_CTRL:   bus_rdata <= ctrl_q;
            OFS_STAT:   bus_rdata <= {flag_q, {(DATA_W-1){1'b0}}};
            OFS_RATE:   bus_rdata <= rate_q;
            default:    bus_rdata <= '0;
         endcase
      end
   end

   // R3
   sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !win_open) |=> (ctrl_q[1:0] == $past(ctrl_q[1:0])));

   // R4
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_hi && !wr_lo && count_o == {CW{1'b1}}) |=> (flag_q && count_o == '0));

   // R5
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[FLAG_BIT] && !wrap) |=> !flag_q);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[IEN_BIT]) |-> !ovf_irq_o);
endmodule

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] count_o;
   logic        ovf_irq_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prescaled_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_o(count_o), .ovf_irq_o(ovf_irq_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R9 count", count_o, 16'h0000);
      check("R8 irq after reset", ovf_irq_o, 1'b0);
      rd(3'd2, d); check("R9 ctrl R10", d, 8'h00);
      rd(3'd3, d); check("R9 status", d, 8'h00);
      rd(3'd4, d); check("R9 rate", d, 8'h00);
      check("R1 divide by one", count_o, 16'h0003);
   endtask

   task automatic t_divider(input logic [1:0] sel, input int div);
      wr(3'd2, {6'd0, sel});
      wr(3'd1, 8'h00);
      check("R6 low write", count_o, 16'h1200);
      edges(div - 1);
      check("R2 before tick", count_o, 16'h1200);
      edges(div + 1);
      check("R2 two ticks", count_o, 16'h1202);
   endtask

   task automatic t_lock();
      logic [7:0] d;
      edges(20);
      wr(3'd2, 8'h84);
      rd(3'd2, d);
      check("R3 select locked", d, 8'h87);
      wr(3'd4, 8'h5A);
      rd(3'd4, d);
      check("R9 rate storage", d, 8'h5A);
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      wr(3'd0, 8'hFF);
      wr(3'd1, 8'hFE);
      edges(15);
      check("R6 phase restart", count_o, 16'hFFFE);
      edges(1);
      check("R2 divide by 16", count_o, 16'hFFFF);
      edges(15);
      check("R8 irq before wrap", ovf_irq_o, 1'b0);
      edges(1);
      check("R1 wrap count", count_o, 16'h0000);
      check("R8 irq on wrap", ovf_irq_o, 1'b1);
      rd(3'd3, d); check("R4 flag set", d, 8'h80);
      wr(3'd2, 8'h03);
      check("R8 irq masked", ovf_irq_o, 1'b0);
      wr(3'd2, 8'h83);
      check("R8 irq unmasked", ovf_irq_o, 1'b1);
      wr(3'd3, 8'h7F);
      rd(3'd3, d); check("R5 zero bit kept", d, 8'h80);
      wr(3'd3, 8'h80);
      rd(3'd3, d); check("R5 one bit clears", d, 8'h00);
      check("R8 irq cleared", ovf_irq_o, 1'b0);
   endtask

   task automatic t_latch();
      logic [7:0]  d;
      logic [15:0] c;
      wr(3'd0, 8'h34);
      wr(3'd1, 8'hFF);
      rd(3'd0, d); check("R7 high read", d, 8'h34);
      edges(40);
      check("R1 ticks after latch", count_o, 16'h3501);
      rd(3'd1, d); check("R7 latched low", d, 8'hFF);
      c = count_o;
      rd(3'd1, d); check("R7 live low", d, c[7:0]);
   endtask

   task automatic t_bytes();
      logic [15:0] c;
      c = count_o;
      wr(3'd0, 8'h56);
      check("R6 high write keeps low", count_o, {8'h56, c[7:0]});
      edges(15);
      check("R6 restart holds", count_o, {8'h56, c[7:0]});
      edges(1);
      check("R6 first tick", count_o, {8'h56, c[7:0]} + 16'd1);
      c = count_o;
      wr(3'd1, 8'h10);
      check("R6 low write keeps high", count_o, {c[15:8], 8'h10});
   endtask

   initial begin
      edges(3);
      rst_n = 1'b1;
      t_reset();
      wr(3'd0, 8'h12);
      t_divider(2'b01, 4);
      t_divider(2'b10, 8);
      t_divider(2'b11, 16);
      t_lock();
      t_overflow();
      t_latch();
      t_bytes();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule